// File: doc/BRIEF.md
# Repeater Port Partition Controller

This block watches one repeater port and decides whether that port is cut off from the repeater core. It runs at bit-time rate, so one clock cycle is one bit time. It partitions the port in two cases: the port's collision indication stays high for too long, or too many colliding packets arrive back to back. While the port is partitioned, its receive carrier sense and its collision indication are masked before they reach the core.

A partitioned port is let back in after a long packet that sees no collision. Two rules decide which packets count:
- The standard rule accepts traffic in either direction.
- The transmit-only rule accepts only packets the repeater sends to the port.

A one-cycle request switches the port to the transmit-only rule. Only reset returns it to the standard rule. Pulling the port enable low parks the controller in an off state. Raising the enable again brings the port back connected, with its collision history cleared.

The controller has five states:
- `ST_OFF`: the port is disabled.
- `ST_LINK_IDLE`: connected, with no traffic.
- `ST_LINK_PKT`: connected, with a packet in progress.
- `ST_CUT_IDLE`: partitioned, waiting for a candidate packet.
- `ST_CUT_PKT`: partitioned, measuring a candidate packet.

Its transitions are:
- enable low: any state goes to `ST_OFF`.
- enable high: `ST_OFF` goes to `ST_LINK_IDLE`.
- traffic start: `ST_LINK_IDLE` goes to `ST_LINK_PKT`.
- traffic end: `ST_LINK_PKT` goes to `ST_LINK_IDLE`.
- trip, on a collision-length or collision-count limit: either connected state goes to `ST_CUT_IDLE`.
- candidate start: `ST_CUT_IDLE` goes to `ST_CUT_PKT`.
- candidate rejected: `ST_CUT_PKT` goes to `ST_CUT_IDLE`.
- candidate accepted: `ST_CUT_PKT` goes to `ST_LINK_IDLE`.

A packet is a run of consecutive cycles with activity. Its end is the first cycle with no activity. Under the standard rule, activity is transmit OR receive. Under the transmit-only rule, a candidate is a run of transmit cycles only.

Top module: `rptr_part_ctrl`

## Requirements
- R1: After reset the port is connected: `seg_cut` is 0. With the port enabled, `crs_fwd` follows `rx_act` and `col_fwd` follows `coll_in`.
- R2: When `coll_in` is sampled high on 1024 consecutive clock edges, `seg_cut` is 1 after the 1024th edge. After only 1023 such edges, `seg_cut` is still 0.
- R3: If 32 packets in a row each carry at least one collision cycle, `seg_cut` is 1 after the end cycle of the 32nd packet. After 31 such packets, `seg_cut` stays 0.
- R4: A packet that ends with no collision cycle restarts the count of R3. After it, 32 more colliding packets are needed to partition the port.
- R5: While `seg_cut` is 1, `crs_fwd` and `col_fwd` are 0, whatever `rx_act` and `coll_in` are.
- R6: Under the standard rule, a partitioned port reconnects (`seg_cut` becomes 0) at the end of a collision-free packet with more than 512 active cycles, whether the activity is transmit or receive. A packet of exactly 512 cycles leaves the port partitioned.
- R7: A candidate packet that carries a collision cycle does not reconnect the port, however long it is.
- R8: One cycle of `alt_set` selects the transmit-only rule, and the selection stays after `alt_set` falls.
  - Under this rule a long, clean receive-only packet does not reconnect the port; a long, clean transmit packet does.
  - Only reset restores the standard rule.
- R9: With `port_en` low, `seg_cut`, `crs_fwd` and `col_fwd` are 0 from the next edge onward.
  - Raising `port_en` returns the port connected.
  - Raising `port_en` also clears the count of colliding packets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Port enable; low disables the port and forces the off state |
| tx_act | input | 1 | Repeater is transmitting onto this port |
| rx_act | input | 1 | Port is receiving |
| coll_in | input | 1 | Collision indication for this port |
| alt_set | input | 1 | One-cycle request for the transmit-only reconnection rule (sticky) |
| seg_cut | output | 1 | Port is partitioned |
| crs_fwd | output | 1 | Receive carrier sense passed to the repeater core |
| col_fwd | output | 1 | Collision indication passed to the repeater core |

## Verification
Two ingredients must line up to partition the port by collision count: 32 colliding packets with no clean packet among them. Once it is partitioned, the port only returns through a long clean packet of the right direction. Directed sequences reach both limits exactly, at 31 versus 32 packets and at 512 versus 513 cycles.

The random phase biases its collision probability on the expected state:
- While the port should be connected, nearly every short packet collides, so the count limit is reached repeatedly.
- While the port should be partitioned, packets are long and mostly clean, so reconnection attempts are frequent under both rules.

// File: rtl/rptr_part_pkg.sv
package rptr_part_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_LINK_IDLE = 3'd1,
        ST_LINK_PKT  = 3'd2,
        ST_CUT_IDLE  = 3'd3,
        ST_CUT_PKT   = 3'd4
    } part_state_e;

    localparam int DEF_COLL_RUN_LIMIT = 1024;
    localparam int DEF_COLL_CNT_LIMIT = 32;
    localparam int DEF_RECON_MIN_LEN  = 512;

endpackage

// File: rtl/part_run_timer.sv
// Counts consecutive cycles of a held condition; flags the LIMIT-th one.
module part_run_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic hit
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = run && (cnt == TOP);

    // R2
    run_hit_needs_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(run));

endmodule

// File: rtl/part_burst_count.sv
// Counts packets in a row that carried a collision.
module part_burst_count #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic pkt_end,
    input  logic had_coll,
    output logic hit
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (pkt_end) begin
            if (had_coll && cnt != TOP) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
            end
        end
    end

    assign hit = !clear && pkt_end && had_coll && (cnt == TOP);

    // R4
    clean_pkt_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_end && !had_coll) |=> (cnt == '0));

    // R3
    burst_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cnt == '0));

endmodule

// File: rtl/part_pkt_meter.sv
// Tracks one activity run: length (saturating) and whether a collision was seen.
module part_pkt_meter #(
    parameter int MIN_LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    input  logic coll,
    output logic pkt_end,
    output logic pkt_long,
    output logic pkt_clean
);
    localparam int SAT = MIN_LEN + 1;
    localparam int LW  = $clog2(SAT + 1);
    localparam logic [LW-1:0] SATV = LW'(SAT);
    localparam logic [LW-1:0] MINV = LW'(MIN_LEN);

    logic          act_q;
    logic [LW-1:0] len;
    logic          seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            len   <= '0;
            seen  <= 1'b0;
        end else begin
            act_q <= act;
            if (act) begin
                if (len != SATV) begin
                    len <= len + 1'b1;
                end
                seen <= seen | coll;
            end else begin
                len  <= '0;
                seen <= 1'b0;
            end
        end
    end

    assign pkt_end   = act_q && !act;
    assign pkt_long  = len > MINV;
    assign pkt_clean = !seen;

    // R7
    coll_marks_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && coll) |=> !pkt_clean);

    // R6
    len_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len <= SATV);

endmodule

// File: rtl/rptr_part_ctrl.sv
module rptr_part_ctrl
    import rptr_part_pkg::*;
#(
    parameter int COLL_RUN_LIMIT = DEF_COLL_RUN_LIMIT,
    parameter int COLL_CNT_LIMIT = DEF_COLL_CNT_LIMIT,
    parameter int RECON_MIN_LEN  = DEF_RECON_MIN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic port_en,
    input  logic tx_act,
    input  logic rx_act,
    input  logic coll_in,
    input  logic alt_set,
    output logic seg_cut,
    output logic crs_fwd,
    output logic col_fwd
);
    part_state_e state, nxt;

    logic alt_q;
    logic any_act, tx_only, coll_g;
    logic any_end, any_long, any_clean;
    logic tx_end, tx_long, tx_clean;
    logic run_hit, burst_hit, trip;
    logic cand_act, cand_end, cand_ok;
    logic linked;

    assign any_act = port_en && (tx_act || rx_act);
    assign tx_only = port_en && tx_act;
    assign coll_g  = port_en && coll_in;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alt_q <= 1'b0;
        end else if (alt_set) begin
            alt_q <= 1'b1;
        end
    end

    part_pkt_meter #(.MIN_LEN(RECON_MIN_LEN)) u_any_meter (
        .clk(clk), .rst_n(rst_n), .act(any_act), .coll(coll_g),
        .pkt_end(any_end), .pkt_long(any_long), .pkt_clean(any_clean)
    );

    part_pkt_meter #(.MIN_LEN(RECON_MIN_LEN)) u_tx_meter (
        .clk(clk), .rst_n(rst_n), .act(tx_only), .coll(coll_g),
        .pkt_end(tx_end), .pkt_long(tx_long), .pkt_clean(tx_clean)
    );

    part_run_timer #(.LIMIT(COLL_RUN_LIMIT)) u_run_timer (
        .clk(clk), .rst_n(rst_n), .run(coll_g), .hit(run_hit)
    );

    part_burst_count #(.LIMIT(COLL_CNT_LIMIT)) u_burst (
        .clk(clk), .rst_n(rst_n), .clear(!linked),
        .pkt_end(any_end), .had_coll(!any_clean), .hit(burst_hit)
    );

    assign trip     = run_hit || burst_hit;
    assign cand_act = alt_q ? tx_only : any_act;
    assign cand_end = alt_q ? tx_end : any_end;
    assign cand_ok  = alt_q ? (tx_long && tx_clean) : (any_long && any_clean);

    always_comb begin
        nxt = state;
        if (!port_en) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:       nxt = ST_LINK_IDLE;
                ST_LINK_IDLE: begin
                    if (trip)         nxt = ST_CUT_IDLE;
                    else if (any_act) nxt = ST_LINK_PKT;
                end
                ST_LINK_PKT: begin
                    if (trip)          nxt = ST_CUT_IDLE;
                    else if (!any_act) nxt = ST_LINK_IDLE;
                end
                ST_CUT_IDLE: begin
                    if (cand_act) nxt = ST_CUT_PKT;
                end
                ST_CUT_PKT: begin
                    if (cand_end) nxt = cand_ok ? ST_LINK_IDLE : ST_CUT_IDLE;
                end
                default:      nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_LINK_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        linked  = (state == ST_LINK_IDLE) || (state == ST_LINK_PKT);
        seg_cut = (state == ST_CUT_IDLE) || (state == ST_CUT_PKT);
        crs_fwd = linked && port_en && rx_act;
        col_fwd = linked && port_en && coll_in;
    end

    // R5
    cut_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_cut |-> (!crs_fwd && !col_fwd));

    // R9
    off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (!seg_cut && !crs_fwd && !col_fwd));

    // R6
    reconnect_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seg_cut) |-> ($past(cand_end) || $past(!port_en)));

    // R8
    alt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alt_q |=> alt_q);

endmodule

// File: tb/rptr_part_ctrl_tb_top.sv
module rptr_part_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n, port_en, tx_act, rx_act, coll_in, alt_set;
    logic seg_cut, crs_fwd, col_fwd;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    bit exp_cut;
    bit exp_alt;
    int exp_cnt;

    always #2 clk = ~clk;

    rptr_part_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_act(tx_act),
        .rx_act(rx_act), .coll_in(coll_in), .alt_set(alt_set),
        .seg_cut(seg_cut), .crs_fwd(crs_fwd), .col_fwd(col_fwd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; port_en = 1'b1; tx_act = 0; rx_act = 0; coll_in = 0; alt_set = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        exp_cut = 0; exp_alt = 0; exp_cnt = 0;
    endtask

    // Reference model applied once per packet, built from R3, R4, R6, R7, R8
    task automatic model_pkt(input int len, input bit has_tx, input bit has_rx, input bit hc);
        if (!exp_cut) begin
            if (hc) begin
                exp_cnt++;
                if (exp_cnt == 32) begin exp_cut = 1; exp_cnt = 0; end
            end else begin
                exp_cnt = 0;
            end
        end else begin
            if (len > 512 && !hc && (exp_alt ? has_tx : (has_tx || has_rx))) begin
                exp_cut = 0; exp_cnt = 0;
            end
        end
    endtask

    // Drives one packet; coll_at < 0 means no collision. Ends with 2 idle cycles.
    task automatic send_pkt(input int len, input bit use_tx, input bit use_rx, input int coll_at);
        for (int i = 0; i < len; i++) begin
            tx_act  = use_tx;
            rx_act  = use_rx;
            coll_in = (i == coll_at);
            tick();
        end
        tx_act = 0; rx_act = 0; coll_in = 0;
        tick();
        tick();
        model_pkt(len, use_tx, use_rx, coll_at >= 0);
    endtask

    task automatic coll_burst(input int n);
        for (int k = 0; k < n; k++) send_pkt(8, 1'b0, 1'b1, 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();

        // R1 reset state and pass-through
        check(seg_cut == 0, "R1 seg_cut after reset", seg_cut, 0);
        rx_act = 1; coll_in = 1; #1;
        check(crs_fwd == 1, "R1 crs_fwd passes", crs_fwd, 1);
        check(col_fwd == 1, "R1 col_fwd passes", col_fwd, 1);
        rx_act = 0; coll_in = 0;
        tick(); tick();

        // R2 continuous collision limit
        coll_in = 1;
        repeat (1023) tick();
        check(seg_cut == 0, "R2 no cut after 1023", seg_cut, 0);
        coll_in = 0; tick();
        check(seg_cut == 0, "R2 no cut after break", seg_cut, 0);
        coll_in = 1;
        repeat (1024) tick();
        check(seg_cut == 1, "R2 cut after 1024", seg_cut, 1);
        // R5 masking while partitioned
        rx_act = 1; #1;
        check(crs_fwd == 0, "R5 crs masked", crs_fwd, 0);
        check(col_fwd == 0, "R5 col masked", col_fwd, 0);
        rx_act = 0; coll_in = 0;
        tick(); tick();

        // R9 disable / re-enable
        port_en = 0; tick();
        check(seg_cut == 0, "R9 off clears cut", seg_cut, 0);
        rx_act = 1; #1;
        check(crs_fwd == 0, "R9 crs off", crs_fwd, 0);
        rx_act = 0;
        port_en = 1; tick();
        rx_act = 1; #1;
        check(crs_fwd == 1, "R9 crs back on", crs_fwd, 1);
        rx_act = 0; tick();
        exp_cut = 0; exp_cnt = 0;

        // R3 count limit
        coll_burst(31);
        check(seg_cut == 0, "R3 no cut after 31", seg_cut, 0);
        coll_burst(1);
        check(seg_cut == 1, "R3 cut after 32", seg_cut, 1);

        // R6 reconnect length boundary (standard, receive)
        send_pkt(512, 1'b0, 1'b1, -1);
        check(seg_cut == 1, "R6 512 keeps cut", seg_cut, 1);
        send_pkt(513, 1'b0, 1'b1, -1);
        check(seg_cut == 0, "R6 513 reconnects", seg_cut, 0);

        // R4 clean packet restarts the count
        coll_burst(31);
        send_pkt(20, 1'b1, 1'b0, -1);
        coll_burst(31);
        check(seg_cut == 0, "R4 count restarted", seg_cut, 0);
        coll_burst(1);
        check(seg_cut == 1, "R4 cut after 32 fresh", seg_cut, 1);

        // R7 collision in candidate
        send_pkt(600, 1'b1, 1'b0, 300);
        check(seg_cut == 1, "R7 colliding candidate rejected", seg_cut, 1);
        send_pkt(600, 1'b1, 1'b0, -1);
        check(seg_cut == 0, "R7 clean candidate accepted", seg_cut, 0);

        // R9 re-enable clears collision count
        coll_burst(31);
        port_en = 0; tick(); port_en = 1; tick();
        exp_cnt = 0;
        coll_burst(1);
        check(seg_cut == 0, "R9 count cleared by re-enable", seg_cut, 0);
        send_pkt(10, 1'b0, 1'b1, -1);

        // R8 transmit-only rule, sticky
        alt_set = 1; tick(); alt_set = 0; tick();
        exp_alt = 1;
        coll_burst(32);
        check(seg_cut == 1, "R8 cut in alt mode", seg_cut, 1);
        send_pkt(600, 1'b0, 1'b1, -1);
        check(seg_cut == 1, "R8 rx-only ignored", seg_cut, 1);
        send_pkt(600, 1'b1, 1'b0, -1);
        check(seg_cut == 0, "R8 tx reconnects", seg_cut, 0);
        do_reset();
        coll_burst(32);
        send_pkt(600, 1'b0, 1'b1, -1);
        check(seg_cut == 0, "R8 reset restores standard", seg_cut, 0);

        // Random phase: standard then transmit-only rule
        for (int phase = 0; phase < 2; phase++) begin
            do_reset();
            if (phase == 1) begin
                alt_set = 1; tick(); alt_set = 0; tick();
                exp_alt = 1;
            end
            for (int p = 0; p < 110; p++) begin
                int len, kind, cat;
                bit tx, rx;
                if (!exp_cut) begin
                    len = 2 + $urandom_range(0, 30);
                    cat = ($urandom_range(0, 99) < 96) ? $urandom_range(0, len - 1) : -1;
                end else begin
                    len = 400 + $urandom_range(0, 300);
                    cat = ($urandom_range(0, 99) < 30) ? $urandom_range(0, len - 1) : -1;
                end
                kind = $urandom_range(0, 2);
                tx = (kind != 1);
                rx = (kind != 0);
                send_pkt(len, tx, rx, cat);
                check(seg_cut == exp_cut,
                      (exp_cut != seg_cut && exp_cut) ? "R3 random partition" : "R6 random reconnect",
                      seg_cut, exp_cut);
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule